// File: doc/BRIEF.md
# Ethernet Frame Statistics Counter Bank

This block keeps traffic statistics for one network port. A bank of 64 counters, each 32 bits wide, is split into a transmit half and a receive half. Each side hands over a finished frame as one beat on a valid/ready stream whose payload is the frame length in bytes. On that beat several counters of that side move together in one clock: the packet total, the byte total, the good-frame total, the good-byte total and exactly one counter of an eight-way frame-size histogram.

Software reaches every counter through a simple register port. The port takes a byte offset, a write enable and write data, and returns read data without a clock delay. A write replaces the selected counter. Slots for error statistics (drops, CRC errors, collisions and so on) exist in the bank but no hardware event moves them, so they only ever hold what software wrote there.

Both frame streams have `*_ready` held high whenever the block is out of reset, so the block never applies back-pressure. A beat counts when its `*_valid` and `*_ready` are both high on a rising clock edge. A source may hold `*_valid` high on back-to-back cycles to report back-to-back frames. While reset is active `*_ready` is low, and a source must hold its beat until ready returns.

Top module: `frame_stat_bank`

## Requirements
- R1: After reset every counter reads 0, and `tx_ready` and `rx_ready` are high from the first clock edge after reset is released.
- R2: An accepted transmit beat of length L adds 1 to counters 1 (packets) and 19 (good frames), and adds L to counters 17 (bytes) and 29 (good bytes).
- R3: An accepted transmit beat adds 1 to exactly one histogram counter, chosen by L as follows:
  - L < 64 goes to counter 7.
  - L = 64 goes to counter 10.
  - 65 to 127 goes to counter 11.
  - 128 to 255 goes to counter 12.
  - 256 to 511 goes to counter 13.
  - 512 to 1023 goes to counter 14.
  - 1024 to 2047 goes to counter 15.
  - L >= 2048 goes to counter 16.
- R4: An accepted receive beat of length L adds 1 to counters 33 and 51, and adds L to counters 49 and 56.
- R5: An accepted receive beat adds 1 to one histogram counter using the same length classes as R3. The counters are 39 (L < 64) and 42 through 48 (64 up to 2048 and more, in that order).
- R6: A transmit beat and a receive beat accepted in the same cycle are both fully applied.
- R7: A read at byte offset 0x200 + 4*i, for i from 0 to 56, returns counter i. The index is the offset masked with 0x1FF and divided by 4, so the two low offset bits are ignored.
- R8: A write at an offset inside the window replaces the selected counter with `reg_wdata` at the next edge. It wins over any frame update aimed at the same counter in that cycle, and the other counters still take their frame updates.
- R9: Every counter wraps modulo 2^32, both when it adds 1 and when it adds a length.
- R10: Offsets below 0x200 or above 0x2E3 are outside the window: a write there changes no counter and a read there returns 0.
- R11: A frame beat is counted only when its valid and ready are both high at the clock edge. Ready is never low outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | Transmit frame-done beat present |
| tx_ready | output | 1 | Transmit beat accepted (high out of reset) |
| tx_len | input | LEN_W | Transmit frame length in bytes |
| rx_valid | input | 1 | Receive frame-done beat present |
| rx_ready | output | 1 | Receive beat accepted (high out of reset) |
| rx_len | input | LEN_W | Receive frame length in bytes |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Register read data, combinational from `reg_addr` |

## Verification
Frame lengths are swept on both sides at every histogram edge: 0, 1, 63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 2047, 2048 and the largest length. This separates an off-by-one bin edge from a wrong bin index. A stream of mixed transmit and receive beats in the same cycles, with lengths from two co-prime strides, tells a missed simultaneous update apart from a crossed index range. Software writes are placed on every index, at the same time as frame beats, just below the wrap point, and outside the window. This distinguishes write priority, modulo arithmetic and address decoding. After each phase all 64 read offsets plus out-of-window offsets are compared with an arithmetic model.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

  localparam int BANK_SIZE = 64;
  localparam int BANK_IW   = $clog2(BANK_SIZE);

  // Counter slots moved by one direction's frame beats.
  typedef struct packed {
    logic [BANK_IW-1:0] pkt;
    logic [BANK_IW-1:0] oct;
    logic [BANK_IW-1:0] frag;
    logic [BANK_IW-1:0] bin0;
    logic [BANK_IW-1:0] good;
    logic [BANK_IW-1:0] good_oct;
  } fsb_map_t;

  localparam fsb_map_t TX_MAP = '{pkt: 6'd1,  oct: 6'd17, frag: 6'd7,
                                  bin0: 6'd10, good: 6'd19, good_oct: 6'd29};
  localparam fsb_map_t RX_MAP = '{pkt: 6'd33, oct: 6'd49, frag: 6'd39,
                                  bin0: 6'd42, good: 6'd51, good_oct: 6'd56};

  // Histogram class: 0 = fragment, 1 = exactly 64, 2..7 = wider ranges.
  function automatic logic [2:0] size_class(input logic [31:0] len);
    logic [2:0] c;
    if (len < 32'd64)        c = 3'd0;
    else if (len == 32'd64)  c = 3'd1;
    else if (len < 32'd128)  c = 3'd2;
    else if (len < 32'd256)  c = 3'd3;
    else if (len < 32'd512)  c = 3'd4;
    else if (len < 32'd1024) c = 3'd5;
    else if (len < 32'd2048) c = 3'd6;
    else                     c = 3'd7;
    return c;
  endfunction

endpackage

// File: rtl/fsb_event_decode.sv
module fsb_event_decode
  import fsb_pkg::*;
#(
  parameter int       NUM_CNT = 64,
  parameter int       LEN_W   = 16,
  parameter fsb_map_t MAP     = TX_MAP
) (
  input  logic             fire,
  input  logic [LEN_W-1:0] len,
  output logic [NUM_CNT-1:0] one_mask,
  output logic [NUM_CNT-1:0] len_mask
);

  logic [2:0]         cls;
  logic [BANK_IW-1:0] bin_slot;

  always_comb begin
    cls = size_class(32'(len));
    if (cls == 3'd0) bin_slot = MAP.frag;
    else             bin_slot = MAP.bin0 + BANK_IW'(cls) - BANK_IW'(1);
  end

  always_comb begin
    one_mask = '0;
    len_mask = '0;
    if (fire) begin
      one_mask[MAP.pkt]      = 1'b1;
      one_mask[MAP.good]     = 1'b1;
      one_mask[bin_slot]     = 1'b1;
      len_mask[MAP.oct]      = 1'b1;
      len_mask[MAP.good_oct] = 1'b1;
    end
  end

endmodule

// File: rtl/fsb_counter_slot.sv
module fsb_counter_slot #(
  parameter int CNT_W = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_one,
  input  logic             tx_add,
  input  logic [LEN_W-1:0] tx_len,
  input  logic             rx_one,
  input  logic             rx_add,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             sw_we,
  input  logic [CNT_W-1:0] sw_data,
  output logic [CNT_W-1:0] cnt_q
);

  logic [CNT_W-1:0] tx_term;
  logic [CNT_W-1:0] rx_term;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    tx_term = tx_add ? CNT_W'(tx_len) : CNT_W'(tx_one);
    rx_term = rx_add ? CNT_W'(rx_len) : CNT_W'(rx_one);
    cnt_d   = cnt_q + tx_term + rx_term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (sw_we) cnt_q <= sw_data;
    else            cnt_q <= cnt_d;
  end

endmodule

// File: rtl/fsb_reg_port.sv
module fsb_reg_port #(
  parameter int ADDR_W   = 10,
  parameter int CNT_W    = 32,
  parameter int NUM_CNT  = 64,
  parameter int LAST_IDX = 56
) (
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [CNT_W-1:0]   cnt [NUM_CNT],
  output logic [NUM_CNT-1:0] sw_we_vec,
  output logic               sw_hit,
  output logic [$clog2(NUM_CNT)-1:0] sw_idx,
  output logic [CNT_W-1:0]   reg_rdata
);

  localparam int IW = $clog2(NUM_CNT);

  logic [6:0] word_sel;
  logic       in_win;
  logic [1:0] unused_low;

  assign unused_low = reg_addr[1:0];

  always_comb begin
    word_sel = reg_addr[8:2];
    in_win   = ((reg_addr >> 9) == ADDR_W'(1)) && (32'(word_sel) <= LAST_IDX);
    sw_idx   = IW'(word_sel);
    sw_hit   = reg_we && in_win;
    sw_we_vec = '0;
    if (sw_hit) sw_we_vec[sw_idx] = 1'b1;
    reg_rdata = in_win ? cnt[sw_idx] : '0;
  end

endmodule

// File: rtl/frame_stat_bank.sv
module frame_stat_bank
  import fsb_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata
);

  localparam int NUM_CNT  = BANK_SIZE;
  localparam int IW       = BANK_IW;
  localparam int LAST_IDX = 56;

  logic               ready_q;
  logic               tx_fire;
  logic               rx_fire;
  logic [NUM_CNT-1:0] tx_one_mask, tx_len_mask;
  logic [NUM_CNT-1:0] rx_one_mask, rx_len_mask;
  logic [NUM_CNT-1:0] sw_we_vec;
  logic               sw_hit;
  logic [IW-1:0]      sw_idx;
  logic [CNT_W-1:0]   cnt_q [NUM_CNT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign tx_ready = ready_q;
  assign rx_ready = ready_q;
  assign tx_fire  = tx_valid && ready_q;
  assign rx_fire  = rx_valid && ready_q;

  fsb_event_decode #(.NUM_CNT(NUM_CNT), .LEN_W(LEN_W), .MAP(TX_MAP)) u_tx_dec (
    .fire(tx_fire), .len(tx_len), .one_mask(tx_one_mask), .len_mask(tx_len_mask)
  );

  fsb_event_decode #(.NUM_CNT(NUM_CNT), .LEN_W(LEN_W), .MAP(RX_MAP)) u_rx_dec (
    .fire(rx_fire), .len(rx_len), .one_mask(rx_one_mask), .len_mask(rx_len_mask)
  );

  fsb_reg_port #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_CNT(NUM_CNT),
                 .LAST_IDX(LAST_IDX)) u_regs (
    .reg_we(reg_we), .reg_addr(reg_addr), .cnt(cnt_q), .sw_we_vec(sw_we_vec),
    .sw_hit(sw_hit), .sw_idx(sw_idx), .reg_rdata(reg_rdata)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_slot
    fsb_counter_slot #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .tx_one(tx_one_mask[g]), .tx_add(tx_len_mask[g]), .tx_len(tx_len),
      .rx_one(rx_one_mask[g]), .rx_add(rx_len_mask[g]), .rx_len(rx_len),
      .sw_we(sw_we_vec[g]), .sw_data(reg_wdata), .cnt_q(cnt_q[g])
    );
  end

endmodule

// File: rtl/fsb_checker.sv
module fsb_checker #(
  parameter int CNT_W   = 32,
  parameter int LEN_W   = 16,
  parameter int NUM_CNT = 64,
  parameter int IW      = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tx_fire,
  input logic               rx_fire,
  input logic               tx_ready,
  input logic               rx_ready,
  input logic [LEN_W-1:0]   rx_len,
  input logic               sw_hit,
  input logic [IW-1:0]      sw_idx,
  input logic [CNT_W-1:0]   reg_wdata,
  input logic [CNT_W-1:0]   cnt_q [NUM_CNT]
);

  // R11: ready never drops once out of reset (from the second cycle on)
  logic seen_edge;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_edge <= 1'b0;
    else        seen_edge <= 1'b1;
  end

  p_ready_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seen_edge |-> (tx_ready && rx_ready));

  // R2: transmit packet counter moves by one per accepted beat
  p_tx_pkt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fire && !(sw_hit && sw_idx == IW'(1)))
      |=> cnt_q[1] == $past(cnt_q[1]) + CNT_W'(1));

  // R2: good-frame counter moves in step with the packet counter
  p_tx_good_tracks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fire && !(sw_hit && (sw_idx == IW'(1) || sw_idx == IW'(19))))
      |=> (cnt_q[19] - $past(cnt_q[19])) == (cnt_q[1] - $past(cnt_q[1])));

  // R4: receive byte counter adds the beat length
  p_rx_oct_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && !(sw_hit && sw_idx == IW'(49)))
      |=> cnt_q[49] == $past(cnt_q[49]) + CNT_W'($past(rx_len)));

  // R8: a software write lands regardless of frame traffic
  p_sw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_hit |=> cnt_q[$past(sw_idx)] == $past(reg_wdata));

  // R6: with no activity the totals hold
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_fire && !rx_fire && !sw_hit)
      |=> ($stable(cnt_q[17]) && $stable(cnt_q[49])));

endmodule

bind frame_stat_bank fsb_checker #(
  .CNT_W(CNT_W), .LEN_W(LEN_W), .NUM_CNT(NUM_CNT), .IW(IW)
) u_fsb_checker (
  .clk(clk), .rst_n(rst_n), .tx_fire(tx_fire), .rx_fire(rx_fire),
  .tx_ready(tx_ready), .rx_ready(rx_ready), .rx_len(rx_len),
  .sw_hit(sw_hit), .sw_idx(sw_idx), .reg_wdata(reg_wdata), .cnt_q(cnt_q)
);

// File: tb/test_frame_stat_bank.sv
module test_frame_stat_bank;

  localparam int CNT_W  = 32;
  localparam int LEN_W  = 16;
  localparam int ADDR_W = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tx_valid = 1'b0, rx_valid = 1'b0;
  logic              tx_ready, rx_ready;
  logic [LEN_W-1:0]  tx_len = '0, rx_len = '0;
  logic              reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [CNT_W-1:0]  reg_wdata = '0;
  logic [CNT_W-1:0]  reg_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] model [64];

  always #5 clk = ~clk;

  frame_stat_bank #(.CNT_W(CNT_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) i_frame_stat_bank (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_len(tx_len),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_len(rx_len),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int hist_slot(input int len, input int frag, input int bin0);
    if (len < 64) return frag;
    if (len == 64) return bin0;
    if (len < 128) return bin0 + 1;
    if (len < 256) return bin0 + 2;
    if (len < 512) return bin0 + 3;
    if (len < 1024) return bin0 + 4;
    if (len < 2048) return bin0 + 5;
    return bin0 + 6;
  endfunction

  function automatic bit in_window(input int a);
    return (a >= 'h200) && (((a & 'h1FF) / 4) <= 56);
  endfunction

  // One clock: optional tx, rx and register write in the same cycle.
  task automatic step(input bit tv, input int tl, input bit rv, input int rl,
                      input bit we, input int a, input logic [31:0] wd);
    @(negedge clk);
    tx_valid = tv; tx_len = LEN_W'(tl);
    rx_valid = rv; rx_len = LEN_W'(rl);
    reg_we = we; reg_addr = ADDR_W'(a); reg_wdata = wd;
    if (tv) begin
      model[1] += 1; model[19] += 1; model[17] += 32'(tl); model[29] += 32'(tl);
      model[hist_slot(tl, 7, 10)] += 1;
    end
    if (rv) begin
      model[33] += 1; model[51] += 1; model[49] += 32'(rl); model[56] += 32'(rl);
      model[hist_slot(rl, 39, 42)] += 1;
    end
    if (we && in_window(a)) model[(a & 'h1FF) / 4] = wd;
    @(negedge clk);
    check("R11", "tx_ready", {31'd0, tx_ready}, 32'd1);
    tx_valid = 1'b0; rx_valid = 1'b0; reg_we = 1'b0;
  endtask

  task automatic read_at(input int a, output logic [31:0] v);
    reg_addr = ADDR_W'(a);
    #1;
    v = reg_rdata;
  endtask

  task automatic check_all(input string req);
    logic [31:0] v;
    for (int i = 0; i < 64; i++) begin
      read_at('h200 + 4 * i, v);
      check(req, $sformatf("counter %0d", i), v, (i <= 56) ? model[i] : 32'd0);
    end
    read_at('h2E3, v);  check("R7", "low bits ignored", v, model[56]);
    read_at('h1FC, v);  check("R10", "read below window", v, 32'd0);
    read_at('h3FC, v);  check("R10", "read above window", v, 32'd0);
  endtask

  task automatic check_one(input string req, input int idx, input logic [31:0] exp);
    logic [31:0] v;
    read_at('h200 + 4 * idx, v);
    check(req, $sformatf("counter %0d", idx), v, exp);
  endtask

  initial begin : watchdog
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int lens [16] = '{0, 1, 63, 64, 65, 127, 128, 255, 256, 511, 512,
                      1023, 1024, 2047, 2048, 65535};
    int sum;
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "rx_ready after reset", {31'd0, rx_ready}, 32'd1);
    check_all("R1");

    // R2/R3: transmit sweep over histogram edges
    sum = 0;
    foreach (lens[k]) begin
      step(1, lens[k], 0, 0, 0, 0, '0);
      sum += lens[k];
      check_all("R3");
    end
    check_one("R2", 1, 32'd16);
    check_one("R2", 17, 32'(sum));
    check_one("R2", 29, 32'(sum));
    check_one("R3", 10, 32'd1);
    check_one("R3", 7, 32'd3);

    // R4/R5: receive sweep
    foreach (lens[k]) begin
      step(0, 0, 1, lens[k], 0, 0, '0);
      check_all("R5");
    end
    check_one("R4", 33, 32'd16);
    check_one("R4", 49, 32'(sum));
    check_one("R4", 51, 32'd16);
    check_one("R5", 48, 32'd2);

    // R6: simultaneous beats, back to back
    for (int i = 0; i < 40; i++)
      step(1, (i * 197) % 2600, 1, (i * 331 + 5) % 2600, 0, 0, '0);
    check_all("R6");

    // R7: overwrite every index
    for (int i = 0; i <= 56; i++)
      step(0, 0, 0, 0, 1, 'h200 + 4 * i, 32'hA500_0000 | 32'(i));
    check_all("R7");

    // R8: write collides with a frame update
    step(1, 100, 1, 70, 1, 'h200 + 4 * 17, 32'h77);
    check_one("R8", 17, 32'h77);
    check_one("R8", 1, 32'hA500_0002);
    check_all("R8");

    // R9: wrap on +1 and on +length
    step(0, 0, 0, 0, 1, 'h200 + 4 * 1, 32'hFFFF_FFFF);
    step(0, 0, 0, 0, 1, 'h200 + 4 * 49, 32'hFFFF_FFF0);
    step(1, 64, 1, 32, 0, 0, '0);
    check_one("R9", 1, 32'd0);
    check_one("R9", 49, 32'h10);
    check_all("R9");

    // R10: writes outside the window
    step(0, 0, 0, 0, 1, 'h100, 32'hDEAD_BEEF);
    step(0, 0, 0, 0, 1, 'h2E4, 32'hDEAD_BEEF);
    step(0, 0, 0, 0, 1, 'h3FC, 32'hDEAD_BEEF);
    step(0, 0, 0, 0, 1, 'h1FC, 32'hDEAD_BEEF);
    check_all("R10");

    // R11: beat offered during reset is not counted
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) model[i] = '0;
    tx_valid = 1'b1; tx_len = 16'd80;
    @(negedge clk);
    check("R11", "tx_ready in reset", {31'd0, tx_ready}, 32'd0);
    tx_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R11");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule